// File: doc/BRIEF.md
# CAN Transmit Request Tracker

This block keeps the transmit-buffer bookkeeping of a CAN controller at register level and leaves out the bit-level side. Software reaches it over a plain 32-bit register bus. Software writes a mask of buffers to the add-request register, and those buffers become pending straight away. A pending buffer stays in flight until the next `tick` strobe. That strobe stands for the moment the frames actually leave the node on the bus.

On a tick, every buffer that is still pending completes. Its pending bit drops and its transmit-occurred bit rises. The TX queue put index moves forward once for each completion, modulo the queue depth, and the get index follows it. The interrupt flags are posted in the same cycle. When loopback is enabled, each completed frame also enters a small receive FIFO status tracker in that same cycle. Software then releases those frames by writing an acknowledge index.

Because completion waits for a tick, software that polls the pending bits really waits. The queue status shows fewer free slots while frames are in flight.

Register map (byte offsets):
- 0x00: control. Bit 0 enables loopback.
- 0x04: add request (write only).
- 0x08: pending (read only).
- 0x0C: occurred (read only).
- 0x10: TX interrupt enable.
- 0x14: interrupt flags.
- 0x18: TX queue status.
- 0x1C: RX FIFO status.
- 0x20: RX acknowledge (write only).

Top module: `can_tx_tracker`

## Requirements
- R1: After reset, pending (0x08), occurred (0x0C) and interrupt flags (0x14) read 0. The TX queue status (0x18) reads 0x0000_0003 and the RX status (0x1C) reads 0.
- R2: A write of mask M to 0x04 sets the pending bits in M in the cycle after the write and clears the occurred bits of the buffers it newly adds. A bit of M whose buffer is already pending is ignored.
- R3: A tick clears every bit that was pending before it and sets the matching occurred bits. A request written in the same cycle as a tick stays pending until the following tick. With no tick, nothing completes.
- R4: Each completion advances the put index by one, modulo 3, and the get index then equals the put index. The TX queue status word carries the put index at bit 16, the get index at bit 8 and the free level in bits 7:0.
- R5: The free level equals 3 minus the number of pending buffers, and it saturates at 0.
- R6: A tick that completes at least one buffer sets interrupt bit 1 (TX queue empty). It sets interrupt bit 0 (transmission complete) only when some completed buffer has its bit set in the TX interrupt enable register (0x10).
- R7: A write to 0x14 clears the interrupt bits that are 1 in the written data. A bit being set in the same cycle wins over the clear.
- R8: With loopback on, each completion adds one frame to the RX FIFO in the same tick and sets interrupt bit 2. Frames beyond the FIFO depth of 4 are dropped. With loopback off, the RX status does not change. The RX status word holds the fill level in bits 6:0, the get index at bit 8 and the put index at bit 16.
- R9: A write of index K to 0x20 releases all frames up to and including slot K. The get index becomes K+1 modulo 4 and the fill level drops by the number of frames released. An acknowledge that would release more frames than the FIFO holds is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Single-cycle strobe that completes every in-flight transmission |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |

## Verification
The bound checker watches four things on every cycle:
- a requested buffer reads as pending after a write with no tick;
- a tick moves every in-flight buffer from pending to occurred;
- a buffer is never pending and occurred at the same time;
- the queue index holds still between ticks and the RX fill level never exceeds the depth.

Some behaviours depend on exact numeric values that the checker does not compute. Only the directed scenarios show them: the exact queue and RX status words across sends, the saturation of the free level, and the TC gating by the enable register. The same holds for dropping of frames on a full FIFO, the rejection of an over-reaching acknowledge, the write-one-to-clear interrupt flags, and the loopback-off path.

// File: rtl/can_tx_tracker.sv
module can_tx_tracker #(
  parameter int NBUF      = 32,
  parameter int TXQ_DEPTH = 3,
  parameter int RXF_DEPTH = 4,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);
  localparam int CNT_W = $clog2(NBUF + 1);
  localparam int TXI_W = (TXQ_DEPTH > 1) ? $clog2(TXQ_DEPTH) : 1;
  localparam int RXI_W = (RXF_DEPTH > 1) ? $clog2(RXF_DEPTH) : 1;
  localparam int RXL_W = $clog2(RXF_DEPTH + 1);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_ADD  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_DONE = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_TXIE = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_IRQ  = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_TXQ  = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_RXST = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] A_RXAK = ADDR_W'(8'h20);

  logic             loopback;
  logic [NBUF-1:0]  pend, done, txie;
  logic [2:0]       irq;
  logic [TXI_W-1:0] txq_put, txq_get;
  logic [RXI_W-1:0] rx_put, rx_get;
  logic [RXL_W-1:0] rx_fill;

  wire wr_add  = reg_we && (reg_addr == A_ADD);
  wire wr_ctrl = reg_we && (reg_addr == A_CTRL);
  wire wr_txie = reg_we && (reg_addr == A_TXIE);
  wire wr_irq  = reg_we && (reg_addr == A_IRQ);
  wire wr_ack  = reg_we && (reg_addr == A_RXAK);

  wire [NBUF-1:0] new_bits = wr_add ? (reg_wdata[NBUF-1:0] & ~pend) : '0;
  wire [NBUF-1:0] fin_bits = tick ? pend : '0;

  wire [CNT_W-1:0] pend_cnt = CNT_W'($countones(pend));
  wire [CNT_W-1:0] fin_cnt  = CNT_W'($countones(fin_bits));

  wire [31:0] txq_sum = 32'(txq_put) + 32'(fin_cnt);
  wire [31:0] tx_free = (32'(pend_cnt) >= 32'(TXQ_DEPTH)) ? 32'd0
                        : 32'(TXQ_DEPTH) - 32'(pend_cnt);

  wire [31:0] rx_space = 32'(RXF_DEPTH) - 32'(rx_fill);
  wire [31:0] rx_acc   = !loopback ? 32'd0
                         : (32'(fin_cnt) > rx_space) ? rx_space : 32'(fin_cnt);
  wire [RXI_W-1:0] ack_idx = reg_wdata[RXI_W-1:0];
  wire [31:0] ack_rel = ((32'(ack_idx) + 32'(RXF_DEPTH) - 32'(rx_get)) % 32'(RXF_DEPTH)) + 32'd1;
  wire        ack_ok  = wr_ack && (32'(ack_idx) < 32'(RXF_DEPTH)) && (ack_rel <= 32'(rx_fill));
  wire [31:0] rx_fill_n = 32'(rx_fill) - (ack_ok ? ack_rel : 32'd0) + rx_acc;

  wire irq_tc  = |(fin_bits & txie);
  wire irq_tfe = fin_cnt != '0;
  wire irq_rx  = rx_acc != 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loopback <= 1'b0;
      pend     <= '0;
      done     <= '0;
      txie     <= '0;
      irq      <= '0;
      txq_put  <= '0;
      txq_get  <= '0;
      rx_put   <= '0;
      rx_get   <= '0;
      rx_fill  <= '0;
    end else begin
      if (wr_ctrl) loopback <= reg_wdata[0];
      if (wr_txie) txie <= reg_wdata[NBUF-1:0];
      pend <= (tick ? '0 : pend) | new_bits;
      done <= (done & ~new_bits) | fin_bits;
      irq  <= (irq & ~(wr_irq ? reg_wdata[2:0] : 3'b000)) | {irq_rx, irq_tfe, irq_tc};
      if (tick) begin
        txq_put <= TXI_W'(txq_sum % 32'(TXQ_DEPTH));
        txq_get <= TXI_W'(txq_sum % 32'(TXQ_DEPTH));
      end
      rx_put  <= RXI_W'((32'(rx_put) + rx_acc) % 32'(RXF_DEPTH));
      if (ack_ok) rx_get <= RXI_W'((32'(ack_idx) + 32'd1) % 32'(RXF_DEPTH));
      rx_fill <= RXL_W'(rx_fill_n);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: reg_rdata = {31'd0, loopback};
      A_PEND: reg_rdata = 32'(pend);
      A_DONE: reg_rdata = 32'(done);
      A_TXIE: reg_rdata = 32'(txie);
      A_IRQ:  reg_rdata = {29'd0, irq};
      A_TXQ:  reg_rdata = (32'(txq_put) << 16) | (32'(txq_get) << 8) | (tx_free & 32'hFF);
      A_RXST: reg_rdata = (32'(rx_put) << 16) | (32'(rx_get) << 8) | (32'(rx_fill) & 32'h7F);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/can_tx_tracker_chk.sv
module can_tx_tracker_chk #(
  parameter int NBUF      = 32,
  parameter int TXQ_DEPTH = 3,
  parameter int RXF_DEPTH = 4,
  parameter int ADDR_W    = 8,
  parameter int TXI_W     = 2,
  parameter int RXL_W     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [NBUF-1:0]   pend,
  input logic [NBUF-1:0]   done,
  input logic [TXI_W-1:0]  txq_put,
  input logic [RXL_W-1:0]  rx_fill
);
  localparam logic [ADDR_W-1:0] ADD_OFS = ADDR_W'(8'h04);

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADD_OFS && !tick) |=>
      ((pend & $past(reg_wdata[NBUF-1:0])) == $past(reg_wdata[NBUF-1:0])));

  // R3
  tick_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (((done & $past(pend)) == $past(pend)) && ((pend & $past(pend)) == '0)));

  // R3
  disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & done) == '0);

  // R4
  idle_put_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(txq_put));

  // R8
  rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rx_fill) <= 32'(RXF_DEPTH));
endmodule

bind can_tx_tracker can_tx_tracker_chk #(
  .NBUF(NBUF), .TXQ_DEPTH(TXQ_DEPTH), .RXF_DEPTH(RXF_DEPTH), .ADDR_W(ADDR_W),
  .TXI_W(TXI_W), .RXL_W(RXL_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .pend(pend), .done(done), .txq_put(txq_put), .rx_fill(rx_fill)
);

// File: tb/can_tx_tracker_tb_top.sv
module can_tx_tracker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  int checks = 0;
  int fails = 0;
  bit ended = 0;

  localparam logic [7:0] CTRL = 8'h00, ADD = 8'h04, PEND = 8'h08, DONE = 8'h0C,
                         TXIE = 8'h10, IRQ = 8'h14, TXQ = 8'h18, RXST = 8'h1C, RXAK = 8'h20;

  can_tx_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #2 clk = ~clk;

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  task automatic chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      fails++;
      $display("FAIL %s: reg 0x%02h actual 0x%08h expected 0x%08h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic wr_with_tick(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d; tick = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; tick = 1'b0;
  endtask

  task automatic t_reset();
    chk(PEND, 32'h0, "R1");
    chk(DONE, 32'h0, "R1");
    chk(IRQ,  32'h0, "R1");
    chk(TXQ,  32'h0000_0003, "R1");
    chk(RXST, 32'h0, "R1");
  endtask

  task automatic t_first_send();
    wr(CTRL, 32'h1);
    wr(ADD, 32'h1);
    chk(PEND, 32'h1, "R2");
    chk(DONE, 32'h0, "R2");
    chk(TXQ,  32'h0000_0002, "R5");
    pulse_tick();
    chk(PEND, 32'h0, "R3");
    chk(DONE, 32'h1, "R3");
    chk(TXQ,  32'h0001_0103, "R4");
    chk(IRQ,  32'h6, "R6");
    chk(RXST, 32'h0001_0001, "R8");
  endtask

  task automatic t_rx_ack();
    wr(RXAK, 32'h0);
    chk(RXST, 32'h0001_0100, "R9");
  endtask

  task automatic t_w1c();
    wr(IRQ, 32'h6);
    chk(IRQ, 32'h0, "R7");
  endtask

  task automatic t_second_send();
    wr(ADD, 32'h1);
    chk(DONE, 32'h0, "R2");
    pulse_tick();
    chk(TXQ,  32'h0002_0203, "R4");
    chk(DONE, 32'h1, "R3");
  endtask

  task automatic t_tc_enable();
    wr(TXIE, 32'h4);
    wr(ADD, 32'hC);
    wr(ADD, 32'h4);
    chk(PEND, 32'hC, "R2");
    chk(TXQ,  32'h0002_0201, "R5");
    pulse_tick();
    chk(TXQ,  32'h0001_0103, "R4");
    chk(IRQ,  32'h7, "R6");
    chk(DONE, 32'hD, "R3");
  endtask

  task automatic t_saturate();
    wr(ADD, 32'hF0);
    chk(TXQ, 32'h0001_0100, "R5");
    pulse_tick();
    chk(TXQ,  32'h0002_0203, "R4");
    chk(RXST, 32'h0001_0104, "R8");
  endtask

  task automatic t_ack_multi();
    wr(RXAK, 32'h2);
    chk(RXST, 32'h0001_0302, "R9");
    wr(RXAK, 32'h1);
    chk(RXST, 32'h0001_0302, "R9");
    wr(RXAK, 32'h0);
    chk(RXST, 32'h0001_0100, "R9");
  endtask

  task automatic t_same_cycle();
    wr(IRQ, 32'h7);
    wr_with_tick(ADD, 32'h100);
    chk(PEND, 32'h100, "R3");
    chk(DONE, 32'hFD, "R3");
    chk(TXQ,  32'h0002_0202, "R5");
    chk(IRQ,  32'h0, "R6");
    repeat (3) @(negedge clk);
    chk(PEND, 32'h100, "R3");
    pulse_tick();
    chk(DONE, 32'h1FD, "R3");
    chk(PEND, 32'h0, "R3");
    chk(RXST, 32'h0002_0101, "R8");
  endtask

  task automatic t_no_loop();
    wr(IRQ, 32'h7);
    wr(CTRL, 32'h0);
    wr(ADD, 32'h200);
    pulse_tick();
    chk(RXST, 32'h0002_0101, "R8");
    chk(IRQ,  32'h2, "R6");
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_send();
    t_rx_ack();
    t_w1c();
    t_second_send();
    t_tc_enable();
    t_saturate();
    t_ack_multi();
    t_same_cycle();
    t_no_loop();
    finish_run();
  end
endmodule